// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Slice

This block compares two unsigned binary words and reports the relation on three
flags: A above B, A below B, and A equal to B. Its basic unit is a 4-bit slice.
The slice scans its bit pairs from the most significant end, and the first pair
that differs settles the result. When all four pairs match, three cascade inputs
from a less significant slice settle it instead. These inputs resolve through a
fixed table, and that table also gives a defined output for every illegal
combination.

The top module is a series chain of `SLICES` slices. Each slice's three flags
drive the cascade inputs of the next more significant slice. The lowest slice
has its cascade inputs tied to "equal", so the chain compares `4*SLICES`-bit
words. The whole block is combinational. It has no clock, no reset and no
storage. Because the inputs and outputs are plain levels, the block has no
valid/ready edge.

Top module: `mag_cmp_chain`

## Requirements
- R1: Bit pairs are examined from bit 3 (most significant) downward; the first unequal pair decides the result, and lower bits and the cascade inputs then have no effect on the outputs.
- R2: When the deciding pair has A=1, B=0 the outputs are (above, below, equal) = (1,0,0); when A=0, B=1 they are (0,1,0).
- R3: With equal nibbles and the equal cascade input high, the outputs are (0,0,1) whatever the other two cascade inputs are.
- R4: With equal nibbles and cascade inputs (above, below, equal) = (1,0,0) or (0,1,0), the outputs copy the cascade inputs.
- R5: With equal nibbles and cascade inputs (1,1,0), all three outputs are 0.
- R6: With equal nibbles and cascade inputs (0,0,0), the outputs are (1,1,0).
- R7: The chain gives results that agree with unsigned greater, less and equal on the full `4*SLICES`-bit operands; slice k takes bits [4k+3:4k], and slice k+1 is the more significant one.
- R8: The least significant slice sees cascade inputs (0,0,1), so equal operands (including all zeros) produce (0,0,1).
- R9: The outputs are a pure function of the present inputs, and at the chain outputs the equal flag is never high together with the above or below flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_word | input | 4*SLICES | Operand A, unsigned, bit 0 least significant |
| b_word | input | 4*SLICES | Operand B, unsigned, bit 0 least significant |
| a_above | output | 1 | High when A > B |
| a_below | output | 1 | High when A < B |
| a_same | output | 1 | High when A == B |

## Verification
A single slice is driven through all 2048 combinations of its two nibbles and three cascade inputs. This separates every decision depth (bit 3, 2, 1 or 0 deciding) from the equal-nibble cases, and within those it covers all eight cascade codes, the illegal ones included. A three-slice chain is then tried with vectors chosen so that the deciding pair falls in the top, middle or bottom slice. These include words that differ only in the last bit, all-zero and all-one operands, and a pattern where the lower slices point against the upper slice's verdict. This shows that an upper slice overrides its lower neighbours. Random operand pairs compared against native relational operators cover the remaining space.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  localparam int unsigned NIB_W = 4;

  typedef struct packed {
    logic above;
    logic below;
    logic same;
  } cmp_flags_t;

  localparam cmp_flags_t FLAGS_TIE_EQUAL = '{above: 1'b0, below: 1'b0, same: 1'b1};
endpackage

// File: rtl/mag_cmp_scan.sv
// Finds the most significant differing bit pair and which word holds the 1.
module mag_cmp_scan #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_bits,
  input  logic [W-1:0] b_bits,
  output logic         differs,
  output logic         a_wins
);
  always_comb begin
    differs = 1'b0;
    a_wins  = 1'b0;
    // Walk upward so the highest differing position is the last one written.
    for (int i = 0; i < W; i++) begin
      if (a_bits[i] != b_bits[i]) begin
        differs = 1'b1;
        a_wins  = a_bits[i];
      end
    end
  end
endmodule

// File: rtl/mag_cmp_resolve.sv
// Resolution of the cascade code when the local words tie.
module mag_cmp_resolve
  import mag_cmp_pkg::*;
(
  input  cmp_flags_t casc,
  output cmp_flags_t tie_out
);
  always_comb begin
    if (casc.same) begin
      tie_out = '{above: 1'b0, below: 1'b0, same: 1'b1};
    end else if (casc.above && casc.below) begin
      tie_out = '{above: 1'b0, below: 1'b0, same: 1'b0};
    end else if (!casc.above && !casc.below) begin
      tie_out = '{above: 1'b1, below: 1'b1, same: 1'b0};
    end else begin
      tie_out = casc;
    end
  end
endmodule

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import mag_cmp_pkg::*;
(
  input  logic [NIB_W-1:0] a_nib,
  input  logic [NIB_W-1:0] b_nib,
  input  logic             casc_above,
  input  logic             casc_below,
  input  logic             casc_same,
  output logic             out_above,
  output logic             out_below,
  output logic             out_same
);
  logic       differs;
  logic       a_wins;
  cmp_flags_t casc_in;
  cmp_flags_t tie_res;

  assign casc_in = '{above: casc_above, below: casc_below, same: casc_same};

  mag_cmp_scan #(.W(NIB_W)) scan_i (
    .a_bits  (a_nib),
    .b_bits  (b_nib),
    .differs (differs),
    .a_wins  (a_wins)
  );

  mag_cmp_resolve resolve_i (
    .casc    (casc_in),
    .tie_out (tie_res)
  );

  always_comb begin
    if (differs) begin
      out_above = a_wins;
      out_below = ~a_wins;
      out_same  = 1'b0;
    end else begin
      out_above = tie_res.above;
      out_below = tie_res.below;
      out_same  = tie_res.same;
    end
  end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int unsigned SLICES = 3
) (
  input  logic [NIB_W*SLICES-1:0] a_word,
  input  logic [NIB_W*SLICES-1:0] b_word,
  output logic                    a_above,
  output logic                    a_below,
  output logic                    a_same
);
  cmp_flags_t link [0:SLICES];

  assign link[0] = FLAGS_TIE_EQUAL;

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    mag_cmp_slice slice_i (
      .a_nib      (a_word[k*NIB_W +: NIB_W]),
      .b_nib      (b_word[k*NIB_W +: NIB_W]),
      .casc_above (link[k].above),
      .casc_below (link[k].below),
      .casc_same  (link[k].same),
      .out_above  (link[k+1].above),
      .out_below  (link[k+1].below),
      .out_same   (link[k+1].same)
    );
  end

  assign a_above = link[SLICES].above;
  assign a_below = link[SLICES].below;
  assign a_same  = link[SLICES].same;
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
  parameter int unsigned SLICES = 3
) (
  input logic [4*SLICES-1:0] a_word,
  input logic [4*SLICES-1:0] b_word,
  input logic                a_above,
  input logic                a_below,
  input logic                a_same
);
  always_comb begin
    // R9
    flag_excl_chk: assert (!(a_same && (a_above || a_below)))
      else $error("equal flag raised with an ordering flag");
    // R7
    above_chk: assert (!(a_word > b_word) || (a_above && !a_below && !a_same))
      else $error("A>B not reported");
    // R7
    below_chk: assert (!(a_word < b_word) || (a_below && !a_above && !a_same))
      else $error("A<B not reported");
    // R8
    same_chk: assert (!(a_word == b_word) || (a_same && !a_above && !a_below))
      else $error("A==B not reported");
  end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.SLICES(SLICES)) chk_i (
  .a_word  (a_word),
  .b_word  (b_word),
  .a_above (a_above),
  .a_below (a_below),
  .a_same  (a_same)
);

// File: tb/mag_cmp_chain_test.sv
module mag_cmp_chain_test;
  localparam int unsigned SL = 3;
  localparam int unsigned WW = 4 * SL;
  localparam int unsigned NV = 10;

  // {a, b, expected (above, below, same)}
  localparam logic [2*WW+2:0] VEC [0:NV-1] = '{
    {12'h000, 12'h000, 3'b001},   // R8 all zeros
    {12'hFFF, 12'hFFF, 3'b001},   // R8 all ones
    {12'h001, 12'h000, 3'b100},   // R7 lsb only
    {12'h000, 12'h001, 3'b010},   // R7
    {12'h800, 12'h7FF, 3'b100},   // R7 top slice overrides
    {12'h7FF, 12'h800, 3'b010},   // R7
    {12'h0F0, 12'h0E1, 3'b100},   // R7 middle slice decides
    {12'h123, 12'h124, 3'b010},   // R7
    {12'hA5A, 12'hA5B, 3'b010},   // R7
    {12'hFFE, 12'hFFF, 3'b010}    // R7
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [WW-1:0] a_word, b_word;
  logic          a_above, a_below, a_same;

  mag_cmp_chain #(.SLICES(SL)) uut (
    .a_word  (a_word),
    .b_word  (b_word),
    .a_above (a_above),
    .a_below (a_below),
    .a_same  (a_same)
  );

  logic [3:0] s_a, s_b;
  logic       s_ca, s_cb, s_cs;
  logic       s_oa, s_ob, s_os;

  mag_cmp_slice slice_uut (
    .a_nib      (s_a),
    .b_nib      (s_b),
    .casc_above (s_ca),
    .casc_below (s_cb),
    .casc_same  (s_cs),
    .out_above  (s_oa),
    .out_below  (s_ob),
    .out_same   (s_os)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b", req, got, exp);
    end
  endtask

  function automatic logic [2:0] ref_slice(input logic [3:0] a, input logic [3:0] b,
                                           input logic [2:0] c);
    if (a > b) return 3'b100;
    if (a < b) return 3'b010;
    if (c[0])  return 3'b001;
    if (c[2:1] == 2'b11) return 3'b000;
    if (c[2:1] == 2'b00) return 3'b110;
    return c;
  endfunction

  function automatic string slice_req(input logic [3:0] a, input logic [3:0] b,
                                      input logic [2:0] c);
    if (a != b) return "R1 R2";
    if (c[0]) return "R3";
    if (c[2:1] == 2'b11) return "R5";
    if (c[2:1] == 2'b00) return "R6";
    return "R4";
  endfunction

  initial begin
    a_word = '0; b_word = '0;
    s_a = '0; s_b = '0; s_ca = 1'b0; s_cb = 1'b0; s_cs = 1'b1;
    #3;
    // R9 state with zero inputs and no clock involvement
    check("R9 idle", {a_above, a_below, a_same}, 3'b001);

    for (int i = 0; i < NV; i++) begin
      a_word = VEC[i][2*WW+2 -: WW];
      b_word = VEC[i][WW+2 -: WW];
      #2;
      check("R7 table", {a_above, a_below, a_same}, VEC[i][2:0]);
    end

    // Exhaustive slice sweep
    for (int i = 0; i < 2048; i++) begin
      logic [10:0] v;
      v = 11'(i);
      s_a = v[10:7]; s_b = v[6:3]; {s_ca, s_cb, s_cs} = v[2:0];
      #2;
      check(slice_req(v[10:7], v[6:3], v[2:0]), {s_oa, s_ob, s_os},
            ref_slice(v[10:7], v[6:3], v[2:0]));
    end

    // R1: lower bits and cascade ignored once bit 3 decides
    s_a = 4'b1000; s_b = 4'b0111; {s_ca, s_cb, s_cs} = 3'b010;
    #2;
    check("R1 msb decides", {s_oa, s_ob, s_os}, 3'b100);

    // R7 random operands against native relations
    for (int i = 0; i < 500; i++) begin
      logic [WW-1:0] ra, rb;
      ra = WW'($urandom);
      rb = (i % 4 == 0) ? (ra ^ WW'(1 << (i % WW))) : WW'($urandom);
      a_word = ra; b_word = rb;
      #2;
      check("R7 random", {a_above, a_below, a_same}, {ra > rb, ra < rb, ra == rb});
    end

    // R8 equal random operands report equality
    a_word = 12'h5C3; b_word = 12'h5C3;
    #2;
    check("R8 equal", {a_above, a_below, a_same}, 3'b001);

    done = 1'b1;
  end

  initial begin
    wait (done || cycles > 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout expected=completion");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule